// File: doc/BRIEF.md
# Latched Two-Way Bus Transceiver

This block moves a byte-wide word between two ports, A and B, in either direction without altering it. Each direction owns a private holding bank. While that direction is selected and its latch control is low, the bank is open: the word on the source port passes straight through, and each clock edge copies it into the bank. When the latch control (or the direction select) goes high, the bank stops sampling. From then on it presents the word it took at the last clock edge during which it was open, and it ignores later changes on the source port.

The destination port is driven only when the direction select and the output control of that direction are both low. A port that is not driven reports an all-zero output-enable vector and an all-zero data vector, so an outer wrapper can turn the pair into a tri-state pin. The two directions are fully independent. If both drive at once, each still follows its own rules, and resolving the clash is left to the system. All six controls are active low. An asynchronous active-low reset clears both banks to zero.

Top module: `latched_bus_xcvr`

## Requirements
- R1: The transfer is non-inverting and WIDTH bits wide (default 8). A driven, open bank presents every bit of its source unchanged.
- R2: When a direction's select and latch control are both low, its bank is open. The driven destination equals the live source input in the same cycle.
- R3: A bank that is open at a rising clock edge stores the source value present at that edge. Once its latch control is high, the bank presents that stored value and ignores source changes.
- R4: While a direction's select is high, its bank keeps its contents whatever its latch control and source do, and its destination is not driven.
- R5: A destination is driven only when its direction select and output control are both low. Its output-enable vector is then all ones.
- R6: When a direction's output control is high, its destination is undriven (output-enable all zeros, data all zeros), whatever the bank state.
- R7: The B-to-A direction behaves the same way through its own three controls. Activity in one direction never changes the other direction's bank or outputs.
- R8: While reset is asserted, both banks hold zero, and a driven port with a closed bank shows zero.
- R9: When both directions drive at the same time, each port still shows its own direction's bank value, with no interaction between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the holding banks |
| rst_n | input | 1 | Asynchronous reset, active low, clears both banks |
| a_in | input | WIDTH | Word arriving on port A |
| a_out | output | WIDTH | Word driven onto port A (B-to-A direction) |
| a_oe | output | WIDTH | All ones when port A is driven, else zeros |
| b_in | input | WIDTH | Word arriving on port B |
| b_out | output | WIDTH | Word driven onto port B (A-to-B direction) |
| b_oe | output | WIDTH | All ones when port B is driven, else zeros |
| ab_sel_n | input | 1 | A-to-B direction select, active low |
| ab_lat_n | input | 1 | A-to-B latch control, active low (low = open) |
| ab_drv_n | input | 1 | A-to-B output control, active low |
| ba_sel_n | input | 1 | B-to-A direction select, active low |
| ba_lat_n | input | 1 | B-to-A latch control, active low (low = open) |
| ba_drv_n | input | 1 | B-to-A output control, active low |

## Verification
The bench changes the source word after a bank closes. A design that kept sampling would show the new word instead of the captured one. It also opens the latch control while the direction select is high, then reselects with the latch closed. A design that let the latch control alone open the bank would show corrupted contents. It raises the output control over an open bank and drives both directions at once, which catches a leaked output enable or a bank shared between the two directions. Random control and data patterns then cover the mixed open, held and undriven combinations against a bench model.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Decoded state of one direction
    typedef struct packed {
        logic pass;   // bank open: source flows through and is sampled
        logic drive;  // destination port actively driven
    } dir_ctl_t;

    typedef enum logic [1:0] {
        BANK_HOLD  = 2'b00,
        BANK_OPEN  = 2'b01
    } bank_mode_e;

endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
    import xcvr_pkg::*;
(
    input  logic     sel_n,
    input  logic     lat_n,
    input  logic     drv_n,
    output dir_ctl_t ctl
);

    always_comb begin
        ctl       = '0;
        // bank opens only when the direction is selected and the latch is open
        ctl.pass  = ~sel_n & ~lat_n;
        // output drive needs both the direction select and the output control
        ctl.drive = ~sel_n & ~drv_n;
    end

endmodule

// File: rtl/xcvr_hold_bank.sv
module xcvr_hold_bank
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dir_ctl_t         ctl,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst,
    output logic [WIDTH-1:0] dst_oe
);

    typedef struct packed {
        logic [WIDTH-1:0] held;
    } bank_state_t;

    bank_state_t      st_d, st_q;
    bank_mode_e       mode;
    logic [WIDTH-1:0] view;

    always_comb begin
        st_d = st_q;
        mode = ctl.pass ? BANK_OPEN : BANK_HOLD;
        if (mode == BANK_OPEN) begin
            st_d.held = src;
        end
        // open bank is transparent; closed bank shows its stored word
        view   = (mode == BANK_OPEN) ? src : st_q.held;
        dst    = ctl.drive ? view : '0;
        dst_oe = {WIDTH{ctl.drive}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/latched_bus_xcvr.sv
module latched_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    input  logic             ab_sel_n,
    input  logic             ab_lat_n,
    input  logic             ab_drv_n,
    input  logic             ba_sel_n,
    input  logic             ba_lat_n,
    input  logic             ba_drv_n
);

    localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

    logic     [NDIR-1:0]            sel_n, lat_n, drv_n;
    logic     [NDIR-1:0][WIDTH-1:0] src, dst, dst_oe;
    dir_ctl_t [NDIR-1:0]            ctl;

    assign sel_n = {ba_sel_n, ab_sel_n};
    assign lat_n = {ba_lat_n, ab_lat_n};
    assign drv_n = {ba_drv_n, ab_drv_n};
    assign src   = {b_in, a_in};

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        xcvr_dir_ctrl u_ctl (
            .sel_n (sel_n[g]),
            .lat_n (lat_n[g]),
            .drv_n (drv_n[g]),
            .ctl   (ctl[g])
        );

        xcvr_hold_bank #(.WIDTH(WIDTH)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl    (ctl[g]),
            .src    (src[g]),
            .dst    (dst[g]),
            .dst_oe (dst_oe[g])
        );
    end

    assign b_out = dst[0];
    assign b_oe  = dst_oe[0];
    assign a_out = dst[1];
    assign a_oe  = dst_oe[1];

    // R5
    ab_drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_sel_n && !ab_drv_n) |-> (b_oe == '1));
    // R6
    ab_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_sel_n || ab_drv_n) |-> (b_oe == '0 && b_out == '0));
    // R2
    ab_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_sel_n && !ab_lat_n && !ab_drv_n) |-> (b_out == a_in));
    // R3
    ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ab_sel_n && !ab_lat_n) && !ab_sel_n && ab_lat_n && !ab_drv_n)
        |-> (b_out == $past(a_in)));
    // R4
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ab_sel_n || ab_lat_n) && $past(!ab_sel_n && !ab_drv_n)
         && !ab_sel_n && ab_lat_n && !ab_drv_n) |-> $stable(b_out));
    // R7
    ba_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_sel_n && !ba_lat_n && !ba_drv_n) |-> (a_out == b_in));
    // R7
    ba_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_sel_n || ba_drv_n) |-> (a_oe == '0 && a_out == '0));
    // R7
    ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ba_sel_n && !ba_lat_n) && !ba_sel_n && ba_lat_n && !ba_drv_n)
        |-> (a_out == $past(b_in)));

endmodule

// File: tb/sim_latched_bus_xcvr.sv
module sim_latched_bus_xcvr;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic ab_sel_n = 1'b1, ab_lat_n = 1'b1, ab_drv_n = 1'b1;
    logic ba_sel_n = 1'b1, ba_lat_n = 1'b1, ba_drv_n = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_ab, m_ba;   // bench model of the two banks

    always #2.5 clk = ~clk;     // 200 MHz

    latched_bus_xcvr #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_sel_n(ab_sel_n), .ab_lat_n(ab_lat_n), .ab_drv_n(ab_drv_n),
        .ba_sel_n(ba_sel_n), .ba_lat_n(ba_lat_n), .ba_drv_n(ba_drv_n)
    );

    function automatic logic [W-1:0] exp_data(logic sel_n, logic lat_n, logic drv_n,
                                              logic [W-1:0] src, logic [W-1:0] held);
        if (sel_n || drv_n) return '0;
        return (!lat_n) ? src : held;
    endfunction

    function automatic logic [W-1:0] exp_oe(logic sel_n, logic drv_n);
        return {W{~sel_n & ~drv_n}};
    endfunction

    task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_ports(string tag_b, string tag_a);
        cmp(tag_b, b_out, exp_data(ab_sel_n, ab_lat_n, ab_drv_n, a_in, m_ab));
        cmp(tag_b, b_oe,  exp_oe(ab_sel_n, ab_drv_n));
        cmp(tag_a, a_out, exp_data(ba_sel_n, ba_lat_n, ba_drv_n, b_in, m_ba));
        cmp(tag_a, a_oe,  exp_oe(ba_sel_n, ba_drv_n));
    endtask

    // drive at negedge, check 1 ns later, advance model at the next posedge
    task automatic step(logic s0, logic l0, logic d0, logic [W-1:0] av,
                        logic s1, logic l1, logic d1, logic [W-1:0] bv,
                        string tag_b, string tag_a);
        @(negedge clk);
        ab_sel_n = s0; ab_lat_n = l0; ab_drv_n = d0; a_in = av;
        ba_sel_n = s1; ba_lat_n = l1; ba_drv_n = d1; b_in = bv;
        #1;
        if (!s0 && !d0 && !s1 && !d1)
            $display("WARNING: both directions driving (bus contention)");
        check_ports(tag_b, tag_a);
        @(posedge clk);
        if (rst_n) begin
            if (!s0 && !l0) m_ab = av;
            if (!s1 && !l1) m_ba = bv;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        string tb, ta;
        void'($urandom(32'd4242));
        m_ab = '0; m_ba = '0;
        // R8: in reset, closed banks driven show zero even with a source present
        step(0,1,0,8'hC3, 0,1,0,8'h3C, "R8 b", "R8 a");
        step(0,0,0,8'h77, 0,0,0,8'h66, "R8 b open", "R8 a open");
        m_ab = '0; m_ba = '0;
        step(0,1,0,8'hC3, 0,1,0,8'h3C, "R8 b held", "R8 a held");
        @(negedge clk); rst_n = 1'b1;
        // R5: driven after reset, bank still zero
        step(0,1,0,8'h99, 1,1,1,8'h00, "R5 b", "R6 a");
        // R2 / R1: transparent, every bit
        step(0,0,0,8'hA5, 1,1,1,8'h00, "R2 b", "R6 a");
        step(0,0,0,8'hFF, 1,1,1,8'h00, "R1 b ones", "R6 a");
        step(0,0,0,8'h3C, 1,1,1,8'h00, "R1 b", "R6 a");
        // R3: close and change source
        step(0,1,0,8'hFF, 1,1,1,8'h00, "R3 b", "R6 a");
        step(0,1,0,8'h00, 1,1,1,8'h00, "R3 b ignore", "R6 a");
        // R4: deselect, open latch control, new source
        step(1,0,0,8'h11, 1,1,1,8'h00, "R4 b float", "R6 a");
        step(1,0,0,8'h22, 1,1,1,8'h00, "R4 b float", "R6 a");
        step(0,1,0,8'h44, 1,1,1,8'h00, "R4 b kept", "R6 a");
        // R6: output control high over an open bank
        step(0,0,1,8'h5A, 1,1,1,8'h00, "R6 b", "R6 a");
        step(0,1,0,8'h00, 1,1,1,8'h00, "R6 b loaded", "R6 a");
        // R7: B-to-A on its own, A-to-B bank untouched
        step(0,1,0,8'hEE, 0,0,0,8'h5A, "R7 b", "R7 a open");
        step(0,1,0,8'hEE, 0,1,0,8'h01, "R7 b", "R7 a held");
        step(1,1,1,8'h00, 1,0,0,8'h02, "R7 b", "R7 a float");
        // R9: both drive
        step(0,0,0,8'h81, 0,1,0,8'h18, "R9 b", "R9 a");
        step(0,1,0,8'h00, 0,0,0,8'h42, "R9 b", "R9 a");

        for (int i = 0; i < 3000; i++) begin
            logic [5:0] c;
            c = 6'($urandom);
            tb = (c[0] | c[2]) ? "R6 rnd b" : (!c[1] ? "R2 rnd b" : "R3 rnd b");
            ta = (c[3] | c[5]) ? "R7 rnd a float" : (!c[4] ? "R7 rnd a open" : "R7 rnd a held");
            step(c[0], c[1], c[2], 8'($urandom), c[3], c[4], c[5], 8'($urandom), tb, ta);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule